// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the host-visible control and status registers for the bus-master DMA function of a two-channel disk interface. Each channel owns a command byte, a status byte and a 32-bit descriptor-table pointer. The host writes them through a simple sized write port and reads them back as aligned 32-bit words. The block then turns those writes into one-cycle start and abort pulses for a per-channel DMA engine, and hands that engine the channel's descriptor pointer.

The engine reports back with a completion pulse and a fault pulse per channel. A completion stops the channel and raises its interrupt flag. A fault raises its error flag. Software clears both flags by writing ones. The transfer-direction bit cannot be changed while a channel is active. Writes of the wrong width are refused and recorded in a sticky flag. All register writes are ignored while the bus-master enable input is low.

Top module: `bmr_dma_regs`

## Requirements
- R1: After reset every status byte reads 0x60, every other register byte reads 0, and `size_err` is 0.
- R2: Channel c uses byte offsets 8c to 8c+7. The command byte is at 8c+0 and the status byte at 8c+2. The descriptor pointer fills 8c+4..8c+7, little-endian. Bytes 8c+1 and 8c+3 read 0. A read returns the aligned word that contains `rd_addr`, with the lowest byte in bits 7:0. Command bits other than 0 (go) and 3 (direction) read 0. Status bits 3, 4 and 7 read 0.
- R3: A command write that changes bit 0 from 0 to 1 sets status bit 0 (active). In the cycle after that write, `dma_start[c]` is high for exactly one cycle, and the channel's `desc_ptr` slice then holds its pointer.
- R4: A command write that changes bit 0 from 1 to 0 clears status bit 0. In the cycle after that write, `dma_abort[c]` is high for exactly one cycle. A write that leaves bit 0 unchanged produces no pulse.
- R5: While status bit 0 is set, a command write keeps the old value of command bit 3. Otherwise command bit 3 takes the written value.
- R6: A host write never changes status bit 0 (active).
- R7: Status bit 2 (interrupt) and bit 1 (error) clear when they are written with 1 and keep their value when written with 0. A host write never sets them. A `dma_fault[c]` pulse sets bit 1. Status bits 6:5 take the written value.
- R8: Command and status accept only byte writes (`wr_size`=0). The pointer accepts only word writes (`wr_size`=2) at offset 8c+4. A stored pointer always has bits 1:0 equal to 0.
- R9: A `xfer_done[c]` pulse clears command bit 0 and status bit 0 and sets status bit 2. It takes effect on the next read.
- R10: While `bm_enable` is 0, writes change no register, produce no pulse and do not set `size_err`.
- R11: Any other enabled write sets `size_err`. The flag stays set until reset. That write leaves all registers unchanged and produces no pulse. This covers the wrong width, offsets 1, 3, 5, 6 and 7, and `wr_size`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_enable | input | 1 | Bus-master function enable; writes are dropped when low |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write byte offset |
| wr_size | input | 2 | Write width: 0 byte, 1 halfword, 2 word, 3 invalid |
| wr_data | input | 32 | Write data, lowest byte in bits 7:0 |
| rd_addr | input | 4 | Host read byte offset (aligned word returned) |
| rd_data | output | 32 | Read data, combinational from the registers |
| xfer_done | input | 2 | Per-channel completion pulse from the DMA engine |
| dma_fault | input | 2 | Per-channel error pulse from the DMA engine |
| dma_start | output | 2 | Per-channel one-cycle start request |
| dma_abort | output | 2 | Per-channel one-cycle abort request |
| desc_ptr | output | 64 | Descriptor pointer per channel, channel c in bits 32c+31:32c |
| size_err | output | 1 | Sticky flag for a refused write |

## Verification
Every control and status bit can be read back combinationally. A wrong go, direction, active, interrupt or error bit therefore shows on `rd_data` in the read that follows the write or pulse that corrupted it. A missed or doubled transition of the go bit shows one cycle after the write, as a missing, extra or two-cycle `dma_start` or `dma_abort` pulse. The bench runs all 256 byte values through each channel's command and status registers. It follows the go/active state arithmetically between writes, so a state error is caught in the same iteration that causes it.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    localparam int CH_BYTES = 8;
    localparam int REG_W    = 32;

    typedef enum logic [1:0] {
        WSZ_BYTE = 2'd0,
        WSZ_HALF = 2'd1,
        WSZ_WORD = 2'd2,
        WSZ_BAD  = 2'd3
    } wsize_e;

    // byte offsets inside one channel window
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_PTR  = 3'd4;

    // bit positions
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_FLO  = 5;
    localparam int ST_FHI  = 6;

    typedef struct packed {
        logic cmd_we;
        logic stat_we;
        logic ptr_we;
    } chan_sel_t;

    function automatic logic write_legal(input logic [2:0] off, input wsize_e sz);
        logic ok;
        ok = 1'b0;
        if ((off == OFF_CMD || off == OFF_STAT) && sz == WSZ_BYTE) ok = 1'b1;
        if (off == OFF_PTR && sz == WSZ_WORD) ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/bmr_wr_decode.sv
module bmr_wr_decode
    import bmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = CH_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bm_enable,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  wsize_e                  wr_size,
    output chan_sel_t [NUM_CH-1:0]  sel_o,
    output logic                    size_err_o
);

    logic            go;
    logic            legal;
    logic [2:0]      off;
    logic [CH_W-1:0] ch;

    always_comb begin
        go    = wr_valid && bm_enable;
        off   = wr_addr[2:0];
        ch    = wr_addr[ADDR_W-1:3];
        legal = write_legal(off, wr_size);
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
            always_comb begin
                sel_o[c] = '0;
                if (go && legal && ch == CH_W'(c)) begin
                    sel_o[c].cmd_we  = (off == OFF_CMD);
                    sel_o[c].stat_we = (off == OFF_STAT);
                    sel_o[c].ptr_we  = (off == OFF_PTR);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            size_err_o <= 1'b0;
        end else if (go && !legal) begin
            size_err_o <= 1'b1;
        end
    end

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !bm_enable |-> (sel_o == '0));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        size_err_o |=> size_err_o);

    assert_disabled_no_err_R10: assert property (@(posedge clk) disable iff (rst)
        (!bm_enable && !size_err_o) |=> !size_err_o);

endmodule

// File: rtl/bmr_chan.sv
module bmr_chan
    import bmr_pkg::*;
#(
    parameter int PTR_W = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_sel_t        sel_i,
    input  logic [PTR_W-1:0] wdata_i,
    input  logic             done_i,
    input  logic             fault_i,
    output logic [7:0]       cmd_o,
    output logic [7:0]       stat_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             start_o,
    output logic             abort_o
);

    logic             go_q;
    logic             dir_q;
    logic             act_q;
    logic             err_q;
    logic             irq_q;
    logic [1:0]       free_q;
    logic [PTR_W-1:0] ptr_q;
    logic             go_rise;
    logic             go_fall;

    always_comb begin
        go_rise = sel_i.cmd_we && !go_q &&  wdata_i[CMD_GO];
        go_fall = sel_i.cmd_we &&  go_q && !wdata_i[CMD_GO];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            dir_q   <= 1'b0;
            act_q   <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            free_q  <= 2'b11;
            ptr_q   <= '0;
            start_o <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            if (sel_i.cmd_we) begin
                go_q <= wdata_i[CMD_GO];
                if (!act_q) dir_q <= wdata_i[CMD_DIR];
            end
            if (go_rise)      act_q <= 1'b1;
            else if (go_fall) act_q <= 1'b0;
            if (sel_i.stat_we) begin
                free_q <= wdata_i[ST_FHI:ST_FLO];
                if (wdata_i[ST_IRQ]) irq_q <= 1'b0;
                if (wdata_i[ST_ERR]) err_q <= 1'b0;
            end
            if (fault_i) err_q <= 1'b1;
            if (sel_i.ptr_we) ptr_q <= {wdata_i[PTR_W-1:2], 2'b00};
            // completion from the engine wins over a same-cycle host write
            if (done_i) begin
                go_q  <= 1'b0;
                act_q <= 1'b0;
                irq_q <= 1'b1;
            end
            start_o <= go_rise;
            abort_o <= go_fall;
        end
    end

    always_comb begin
        cmd_o  = {4'b0000, dir_q, 2'b00, go_q};
        stat_o = {1'b0, free_q, 2'b00, irq_q, err_q, act_q};
        ptr_o  = ptr_q;
    end

    assert_start_active_R3: assert property (@(posedge clk) disable iff (rst)
        (start_o && !$past(done_i)) |-> act_q);

    assert_abort_idle_R4: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !act_q);

    assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(start_o && abort_o));

    assert_dir_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_i.cmd_we && act_q) |=> $stable(dir_q));

    assert_act_ro_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_i.stat_we && !done_i) |=> $stable(act_q));

    assert_irq_no_set_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_i.stat_we && !done_i) |=> !$rose(irq_q));

    assert_err_no_set_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_i.stat_we && !fault_i) |=> !$rose(err_q));

    assert_done_R9: assert property (@(posedge clk) disable iff (rst)
        done_i |=> (irq_q && !act_q && !go_q));

endmodule

// File: rtl/bmr_dma_regs.sv
module bmr_dma_regs
    import bmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + $clog2(CH_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bm_enable,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [1:0]              wr_size,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]       xfer_done,
    input  logic [NUM_CH-1:0]       dma_fault,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_abort,
    output logic [NUM_CH*REG_W-1:0] desc_ptr,
    output logic                    size_err
);

    chan_sel_t [NUM_CH-1:0] sel;
    logic [7:0]             cmd_b  [NUM_CH];
    logic [7:0]             stat_b [NUM_CH];
    logic [REG_W-1:0]       ptr_w  [NUM_CH];
    logic [CH_W-1:0]        rd_ch;

    bmr_wr_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) dec_i (
        .clk        (clk),
        .rst        (rst),
        .bm_enable  (bm_enable),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_size    (wsize_e'(wr_size)),
        .sel_o      (sel),
        .size_err_o (size_err)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            bmr_chan #(
                .PTR_W (REG_W)
            ) chan_i (
                .clk     (clk),
                .rst     (rst),
                .sel_i   (sel[c]),
                .wdata_i (wr_data),
                .done_i  (xfer_done[c]),
                .fault_i (dma_fault[c]),
                .cmd_o   (cmd_b[c]),
                .stat_o  (stat_b[c]),
                .ptr_o   (ptr_w[c]),
                .start_o (dma_start[c]),
                .abort_o (dma_abort[c])
            );
            assign desc_ptr[c*REG_W +: REG_W] = ptr_w[c];
        end
    endgenerate

    always_comb begin
        rd_ch = rd_addr[ADDR_W-1:3];
        if (rd_addr[2]) begin
            rd_data = ptr_w[rd_ch];
        end else begin
            rd_data = {8'h00, stat_b[rd_ch], 8'h00, cmd_b[rd_ch]};
        end
    end

endmodule

// File: tb/bmr_dma_regs_tb.sv
module bmr_dma_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           bm_enable;
    logic           wr_valid;
    logic [3:0]     wr_addr;
    logic [1:0]     wr_size;
    logic [31:0]    wr_data;
    logic [3:0]     rd_addr;
    logic [31:0]    rd_data;
    logic [1:0]     xfer_done;
    logic [1:0]     dma_fault;
    logic [1:0]     dma_start;
    logic [1:0]     dma_abort;
    logic [63:0]    desc_ptr;
    logic           size_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  m_cmd  [NCH];
    logic [7:0]  m_stat [NCH];
    logic [31:0] m_ptr  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmr_dma_regs #(.NUM_CH(NCH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bm_enable (bm_enable),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_size   (wr_size),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .xfer_done (xfer_done),
        .dma_fault (dma_fault),
        .dma_start (dma_start),
        .dma_abort (dma_abort),
        .desc_ptr  (desc_ptr),
        .size_err  (size_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_size  = sz;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rdw(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse_done(input int c);
        @(negedge clk);
        xfer_done[c] = 1'b1;
        @(negedge clk);
        xfer_done = '0;
        m_cmd[c][0]  = 1'b0;
        m_stat[c][0] = 1'b0;
        m_stat[c][2] = 1'b1;
    endtask

    task automatic pulse_fault(input int c);
        @(negedge clk);
        dma_fault[c] = 1'b1;
        @(negedge clk);
        dma_fault = '0;
        m_stat[c][1] = 1'b1;
    endtask

    task automatic check_all(input string req);
        logic [31:0] w;
        for (int c = 0; c < NCH; c++) begin
            rdw(4'(8*c), w);
            chk(w, {8'h00, m_stat[c], 8'h00, m_cmd[c]}, req, "ctl word");
            rdw(4'(8*c + 4), w);
            chk(w, m_ptr[c], req, "ptr word");
        end
    endtask

    // command write with model update and pulse checks (R3 R4 R5)
    task automatic do_cmd(input int c, input logic [7:0] b);
        logic s, d, a, es, ea;
        logic [31:0] w;
        s  = m_cmd[c][0];
        d  = m_cmd[c][3];
        a  = m_stat[c][0];
        es = !s && b[0];
        ea = s && !b[0];
        m_cmd[c] = {4'b0000, (a ? d : b[3]), 2'b00, b[0]};
        if (es) m_stat[c][0] = 1'b1;
        else if (ea) m_stat[c][0] = 1'b0;
        wr(4'(8*c), 2'd0, {24'h0, b});
        chk({30'b0, dma_start}, {30'b0, (es ? 2'(1 << c) : 2'b00)}, "R3", "start pulse");
        chk({30'b0, dma_abort}, {30'b0, (ea ? 2'(1 << c) : 2'b00)}, "R4", "abort pulse");
        if (es) chk(desc_ptr[c*32 +: 32], m_ptr[c], "R3", "ptr with start");
        rdw(4'(8*c), w);
        chk(w, {8'h00, m_stat[c], 8'h00, m_cmd[c]}, "R5", "cmd/stat after cmd write");
        @(negedge clk);
        chk({28'b0, dma_start, dma_abort}, 32'h0, "R3", "pulse one cycle");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        rst = 1'b1; bm_enable = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_size = '0;
        wr_data = '0; rd_addr = '0; xfer_done = '0; dma_fault = '0;
        for (int c = 0; c < NCH; c++) begin
            m_cmd[c] = 8'h00; m_stat[c] = 8'h60; m_ptr[c] = 32'h0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_all("R1");
        chk({31'b0, size_err}, 32'h0, "R1", "size_err after reset");
        chk({28'b0, dma_start, dma_abort}, 32'h0, "R1", "pulses after reset");

        // R8 pointer stores with low bits forced to zero; R2 lane layout
        wr(4'd4, 2'd2, 32'h1234_5677);
        m_ptr[0] = 32'h1234_5674;
        wr(4'd12, 2'd2, 32'hDEAD_BEEF);
        m_ptr[1] = 32'hDEAD_BEEC;
        rdw(4'd4, w);  chk(w, 32'h1234_5674, "R8", "ch0 ptr aligned");
        rdw(4'd12, w); chk(w, 32'hDEAD_BEEC, "R8", "ch1 ptr aligned");
        chk(desc_ptr, {32'hDEAD_BEEC, 32'h1234_5674}, "R2", "desc_ptr slices");

        // R3 R4 R5 sweep of every command byte on each channel
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v < 256; v++) begin
                do_cmd(c, 8'(v));
            end
            check_all("R2");
        end

        // R6 R7 sweep of every status byte with faults and completions mixed in
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                logic act_before;
                b = 8'(v);
                if (v % 3 == 0) pulse_fault(c);
                if (v % 7 == 0) pulse_done(c);
                if (v % 11 == 0) do_cmd(c, 8'h01);
                act_before = m_stat[c][0];
                m_stat[c] = {1'b0, b[6:5], 2'b00,
                             m_stat[c][2] & ~b[2], m_stat[c][1] & ~b[1], act_before};
                wr(4'(8*c + 2), 2'd0, {24'h0, b});
                rdw(4'(8*c), w);
                chk({31'b0, w[16]}, {31'b0, act_before}, "R6", "active read-only");
                chk({24'b0, w[23:16]}, {24'b0, m_stat[c]}, "R7", "status after write");
            end
        end

        // R9 completion on an active channel
        for (int c = 0; c < NCH; c++) begin
            do_cmd(c, 8'h00);
            do_cmd(c, 8'h09);
            rdw(4'(8*c), w);
            chk({31'b0, w[16]}, 32'h1, "R3", "active set by start");
            pulse_done(c);
            rdw(4'(8*c), w);
            chk({31'b0, w[0]}, 32'h0, "R9", "go cleared");
            chk({29'b0, w[18:16]}, {29'b0, 1'b1, m_stat[c][1], 1'b0}, "R9", "irq set active clear");
            chk({31'b0, w[3]}, 32'h1, "R9", "direction kept");
        end

        // R10 writes dropped while disabled
        bm_enable = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            wr(4'(8*c), 2'd0, 32'h0000_0001);
            chk({30'b0, dma_start}, 32'h0, "R10", "no start while disabled");
            wr(4'(8*c + 2), 2'd0, 32'h0000_00FF);
            wr(4'(8*c + 4), 2'd2, 32'hFFFF_FFFF);
            wr(4'(8*c), 2'd1, 32'h0000_FFFF);
        end
        check_all("R10");
        chk({31'b0, size_err}, 32'h0, "R10", "no size error while disabled");
        bm_enable = 1'b1;

        // R11 refused writes
        wr(4'd0, 2'd1, 32'h0000_0001);
        chk({30'b0, dma_start}, 32'h0, "R11", "no start on halfword cmd");
        chk({31'b0, size_err}, 32'h1, "R11", "size_err set");
        wr(4'd2, 2'd2, 32'h0000_0006);
        wr(4'd12, 2'd0, 32'h0000_00FF);
        wr(4'd9, 2'd0, 32'h0000_0001);
        wr(4'd8, 2'd3, 32'h0000_0001);
        wr(4'd10, 2'd1, 32'h0000_0006);
        chk({28'b0, dma_start, dma_abort}, 32'h0, "R11", "no pulse on refused");
        check_all("R11");
        repeat (3) @(negedge clk);
        chk({31'b0, size_err}, 32'h1, "R11", "size_err sticky");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule